// File: doc/BRIEF.md
# Banked Stack Pointer Selector

This block holds four stack-pointer registers, one per privilege level 0 to 3, and decides which one the architectural stack pointer currently names. The choice depends on the current level and a one-bit stack-select flag. At level 0 the shared level-0 register is always used. At levels 1 to 3 the flag picks between the shared register (flag 0) and the level's own register (flag 1).

The block tracks a mode that pairs the level with the flag. Software can write the stack pointer and the flag at any time. An entry strobe with a target level moves the block to that level with the flag forced to 1 and all four interrupt mask bits set. On entry the block also records the prior live status word and a vector offset class. A return strobe restores level, flag and mask bits from a supplied status word.

The mode machine has eight states, named by level and stack: `M0_SHR`, `M0_OWN`, `M1_SHR`, `M1_OWN`, `M2_SHR`, `M2_OWN`, `M3_SHR`, `M3_OWN`. The state is encoded as {level, flag}. At each edge exactly one event applies, chosen in priority order. `EV_ENTER` moves the block to `Mt_OWN` for target t. `EV_RETURN` moves it to the state named by the status word. `EV_SELWR` keeps the level and sets the flag from the written bit. `EV_NONE` holds the state.

Top module: `banked_sp_select`

## Requirements
- R1: After reset the mode is level 3 with the flag at 1 and all mask bits set, so `live_status` reads 0x3CD. All four stack registers, `sp_rdata`, `saved_status` and `vec_offset` read 0.
- R2: `sp_rdata` shows register 0 when the level is 0 or the flag is 0. Otherwise it shows the register whose index equals the level.
- R3: An SP write updates only the register mapped at that edge. It is visible on `sp_rdata` after the edge, and the other three registers keep their values.
- R4: A flag write alone, at any level, sets the flag from `sel_wr_data` after the edge, and the mapping follows it immediately.
- R5: A valid entry sets the level to `exc_target`, the flag to 1 and mask bits 9:6 to 1111. The live status layout is bits 9:6 mask, bits 5:4 zero, bits 3:2 level, bit 1 zero, bit 0 flag.
- R6: A valid entry copies the live status word from before the edge into `saved_status`, which then holds until the next valid entry.
- R7: On a valid entry, `vec_offset` becomes 0x000 when the target equals the current level and register 0 was mapped. It becomes 0x200 when the target equals the current level and the level's own register was mapped. It becomes 0x400 when the target is above the current level.
- R8: An entry with target 0, or with a target below the current level, is treated as if no entry were strobed. Mode, masks, `saved_status` and `vec_offset` are left unchanged.
- R9: A return whose status word has bits 5, 4 and 1 clear sets the level from bits 3:2, the flag from bit 0 and the masks from bits 9:6. A flag written earlier in the handler has no effect on this.
- R10: A return whose status word has any of bits 5, 4 or 1 set is treated as absent.
- R11: A valid entry has priority over a return and over a flag write in the same cycle. A return has priority over a flag write. An SP write in the same cycle as an entry goes to the register mapped before the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_wr_en | input | 1 | Write the currently mapped stack register |
| sp_wr_data | input | SP_W | Data for the stack-register write |
| sel_wr_en | input | 1 | Write the stack-select flag |
| sel_wr_data | input | 1 | New flag value |
| exc_enter | input | 1 | Exception entry strobe |
| exc_target | input | 2 | Target level of the entry |
| exc_return | input | 1 | Exception return strobe |
| ret_status | input | 10 | Status word restored on return |
| sp_rdata | output | SP_W | Value of the mapped stack register |
| live_status | output | 10 | Packed live mode: masks, level, flag |
| saved_status | output | 10 | Live status captured at the last valid entry |
| vec_offset | output | VEC_W | Vector offset class of the last valid entry |

## Verification
The hardest case to reach is a same-level entry taken while the shared register is mapped at a raised level, combined with a simultaneous SP write. Entries only force the flag to 1, so this state cannot be reached by entries alone. The bench uses the return strobe with a crafted status word to land directly in every one of the eight modes, with varied mask patterns. From each mode it then fires every target level, with and without a concurrent SP write, flag write or return. It checks the register that received the write by toggling the flag afterwards.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int MASK_W  = 4;
    localparam int STAT_W  = 10;

    // Bits of the status word that must be zero in a return word
    localparam logic [STAT_W-1:0] RSV_BITS = 10'b00_0011_0010;

    // State encoding is {level, flag}
    typedef enum logic [2:0] {
        M0_SHR = 3'b000,
        M0_OWN = 3'b001,
        M1_SHR = 3'b010,
        M1_OWN = 3'b011,
        M2_SHR = 3'b100,
        M2_OWN = 3'b101,
        M3_SHR = 3'b110,
        M3_OWN = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_ENTER,
        EV_RETURN,
        EV_SELWR
    } event_e;
endpackage

// File: rtl/bsp_event_arb.sv
module bsp_event_arb
    import bsp_pkg::*;
(
    input  logic                 exc_enter,
    input  logic [LVL_W-1:0]     exc_target,
    input  logic                 exc_return,
    input  logic [STAT_W-1:0]    ret_status,
    input  logic                 sel_wr_en,
    input  logic [LVL_W-1:0]     cur_lvl,
    output event_e               ev
);
    logic enter_ok;
    logic return_ok;

    always_comb begin
        enter_ok  = exc_enter && (exc_target != '0) && (exc_target >= cur_lvl);
        return_ok = exc_return && ((ret_status & RSV_BITS) == '0);
        if (enter_ok)
            ev = EV_ENTER;
        else if (return_ok)
            ev = EV_RETURN;
        else if (sel_wr_en)
            ev = EV_SELWR;
        else
            ev = EV_NONE;
    end
endmodule

// File: rtl/bsp_mode_fsm.sv
module bsp_mode_fsm
    import bsp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  event_e               ev,
    input  logic [LVL_W-1:0]     exc_target,
    input  logic                 sel_wr_data,
    input  logic [MASK_W-1:0]    ret_mask,
    input  logic [LVL_W-1:0]     ret_lvl,
    input  logic                 ret_sel,
    output logic [LVL_W-1:0]     cur_lvl,
    output logic                 cur_sel,
    output logic [LVL_W-1:0]     bank_idx,
    output logic [STAT_W-1:0]    live_status
);
    mode_e             state_q, state_d;
    logic [MASK_W-1:0] mask_q, mask_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        unique case (ev)
            EV_ENTER: begin
                state_d = mode_e'({exc_target, 1'b1});
                mask_d  = '1;
            end
            EV_RETURN: begin
                state_d = mode_e'({ret_lvl, ret_sel});
                mask_d  = ret_mask;
            end
            EV_SELWR: begin
                state_d = mode_e'({cur_lvl, sel_wr_data});
            end
            EV_NONE: begin
                state_d = state_q;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= M3_OWN;
            mask_q  <= '1;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
        end
    end

    // Output decode
    always_comb begin
        unique case (state_q)
            M0_SHR: begin cur_lvl = 2'd0; cur_sel = 1'b0; bank_idx = 2'd0; end
            M0_OWN: begin cur_lvl = 2'd0; cur_sel = 1'b1; bank_idx = 2'd0; end
            M1_SHR: begin cur_lvl = 2'd1; cur_sel = 1'b0; bank_idx = 2'd0; end
            M1_OWN: begin cur_lvl = 2'd1; cur_sel = 1'b1; bank_idx = 2'd1; end
            M2_SHR: begin cur_lvl = 2'd2; cur_sel = 1'b0; bank_idx = 2'd0; end
            M2_OWN: begin cur_lvl = 2'd2; cur_sel = 1'b1; bank_idx = 2'd2; end
            M3_SHR: begin cur_lvl = 2'd3; cur_sel = 1'b0; bank_idx = 2'd0; end
            M3_OWN: begin cur_lvl = 2'd3; cur_sel = 1'b1; bank_idx = 2'd3; end
        endcase
        live_status = {mask_q, 2'b00, cur_lvl, 1'b0, cur_sel};
    end
endmodule

// File: rtl/bsp_bank.sv
module bsp_bank
    import bsp_pkg::*;
#(
    parameter int SP_W = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [LVL_W-1:0]     wr_idx,
    input  logic [SP_W-1:0]      wr_data,
    input  logic [LVL_W-1:0]     rd_idx,
    output logic [SP_W-1:0]      rd_data
);
    logic [SP_W-1:0] bank_q [NUM_LVL];

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[g] <= '0;
            else if (wr_en && (wr_idx == LVL_W'(g)))
                bank_q[g] <= wr_data;
        end
    end

    assign rd_data = bank_q[rd_idx];
endmodule

// File: rtl/bsp_capture.sv
module bsp_capture
    import bsp_pkg::*;
#(
    parameter int                VEC_W        = 12,
    parameter logic [VEC_W-1:0]  VEC_SAME_SHR = 12'h000,
    parameter logic [VEC_W-1:0]  VEC_SAME_OWN = 12'h200,
    parameter logic [VEC_W-1:0]  VEC_LOWER    = 12'h400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  event_e               ev,
    input  logic [LVL_W-1:0]     exc_target,
    input  logic [LVL_W-1:0]     cur_lvl,
    input  logic [LVL_W-1:0]     bank_idx,
    input  logic [STAT_W-1:0]    live_status,
    output logic [STAT_W-1:0]    saved_status,
    output logic [VEC_W-1:0]     vec_offset
);
    logic [VEC_W-1:0] vec_class;

    always_comb begin
        if (exc_target != cur_lvl)
            vec_class = VEC_LOWER;
        else if (bank_idx == '0)
            vec_class = VEC_SAME_SHR;
        else
            vec_class = VEC_SAME_OWN;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_status <= '0;
            vec_offset   <= '0;
        end else if (ev == EV_ENTER) begin
            saved_status <= live_status;
            vec_offset   <= vec_class;
        end
    end
endmodule

// File: rtl/banked_sp_select.sv
module banked_sp_select
    import bsp_pkg::*;
#(
    parameter int                SP_W         = 64,
    parameter int                VEC_W        = 12,
    parameter logic [VEC_W-1:0]  VEC_SAME_SHR = 12'h000,
    parameter logic [VEC_W-1:0]  VEC_SAME_OWN = 12'h200,
    parameter logic [VEC_W-1:0]  VEC_LOWER    = 12'h400
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sp_wr_en,
    input  logic [SP_W-1:0]      sp_wr_data,
    input  logic                 sel_wr_en,
    input  logic                 sel_wr_data,
    input  logic                 exc_enter,
    input  logic [1:0]           exc_target,
    input  logic                 exc_return,
    input  logic [9:0]           ret_status,
    output logic [SP_W-1:0]      sp_rdata,
    output logic [9:0]           live_status,
    output logic [9:0]           saved_status,
    output logic [VEC_W-1:0]     vec_offset
);
    event_e           ev;
    logic [LVL_W-1:0] cur_lvl;
    logic             cur_sel;
    logic [LVL_W-1:0] bank_idx;

    bsp_event_arb u_arb (
        .exc_enter  (exc_enter),
        .exc_target (exc_target),
        .exc_return (exc_return),
        .ret_status (ret_status),
        .sel_wr_en  (sel_wr_en),
        .cur_lvl    (cur_lvl),
        .ev         (ev)
    );

    bsp_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .exc_target  (exc_target),
        .sel_wr_data (sel_wr_data),
        .ret_mask    (ret_status[9:6]),
        .ret_lvl     (ret_status[3:2]),
        .ret_sel     (ret_status[0]),
        .cur_lvl     (cur_lvl),
        .cur_sel     (cur_sel),
        .bank_idx    (bank_idx),
        .live_status (live_status)
    );

    bsp_bank #(.SP_W(SP_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sp_wr_en),
        .wr_idx  (bank_idx),
        .wr_data (sp_wr_data),
        .rd_idx  (bank_idx),
        .rd_data (sp_rdata)
    );

    bsp_capture #(
        .VEC_W        (VEC_W),
        .VEC_SAME_SHR (VEC_SAME_SHR),
        .VEC_SAME_OWN (VEC_SAME_OWN),
        .VEC_LOWER    (VEC_LOWER)
    ) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .exc_target   (exc_target),
        .cur_lvl      (cur_lvl),
        .bank_idx     (bank_idx),
        .live_status  (live_status),
        .saved_status (saved_status),
        .vec_offset   (vec_offset)
    );
endmodule

// File: rtl/bsp_checker.sv
module bsp_checker #(
    parameter int                SP_W      = 64,
    parameter int                VEC_W     = 12,
    parameter logic [VEC_W-1:0]  VEC_LOWER = 12'h400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sp_wr_en,
    input logic [SP_W-1:0]   sp_wr_data,
    input logic              sel_wr_en,
    input logic              sel_wr_data,
    input logic              exc_enter,
    input logic [1:0]        exc_target,
    input logic              exc_return,
    input logic [9:0]        ret_status,
    input logic [SP_W-1:0]   sp_rdata,
    input logic [9:0]        live_status,
    input logic [9:0]        saved_status,
    input logic [VEC_W-1:0]  vec_offset
);
    logic ent_ok;
    logic ret_ok;
    logic quiet;

    assign ent_ok = exc_enter && (exc_target != 2'd0) && (exc_target >= live_status[3:2]);
    assign ret_ok = exc_return && (ret_status[5:4] == 2'b00) && !ret_status[1];
    assign quiet  = !ent_ok && !ret_ok && !sel_wr_en;

    AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ent_ok |=> (live_status[3:2] == $past(exc_target)) && live_status[0]
                   && (live_status[9:6] == 4'hF)); // R5
    AST_ENTRY_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ent_ok |=> saved_status == $past(live_status)); // R6
    AST_ENTRY_LOWER_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (ent_ok && (exc_target > live_status[3:2])) |=> vec_offset == VEC_LOWER); // R7
    AST_BAD_ENTRY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_enter && quiet) |=> (live_status == $past(live_status))
                                 && (saved_status == $past(saved_status))); // R8
    AST_RETURN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_ok && !ent_ok) |=> (live_status[3:2] == $past(ret_status[3:2]))
                                && (live_status[0] == $past(ret_status[0]))
                                && (live_status[9:6] == $past(ret_status[9:6]))); // R9
    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr_en && !ent_ok && !ret_ok) |=> live_status[0] == $past(sel_wr_data)); // R4
    AST_SP_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr_en && !exc_enter && !exc_return && !sel_wr_en) |=> sp_rdata == $past(sp_wr_data)); // R3
endmodule

bind banked_sp_select bsp_checker #(
    .SP_W      (SP_W),
    .VEC_W     (VEC_W),
    .VEC_LOWER (VEC_LOWER)
) u_bsp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .sp_wr_en     (sp_wr_en),
    .sp_wr_data   (sp_wr_data),
    .sel_wr_en    (sel_wr_en),
    .sel_wr_data  (sel_wr_data),
    .exc_enter    (exc_enter),
    .exc_target   (exc_target),
    .exc_return   (exc_return),
    .ret_status   (ret_status),
    .sp_rdata     (sp_rdata),
    .live_status  (live_status),
    .saved_status (saved_status),
    .vec_offset   (vec_offset)
);

// File: tb/banked_sp_select_bench.sv
`timescale 1ns/1ps
module banked_sp_select_bench;
    localparam int SP_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sp_wr_en = 1'b0;
    logic [SP_W-1:0] sp_wr_data = '0;
    logic            sel_wr_en = 1'b0;
    logic            sel_wr_data = 1'b0;
    logic            exc_enter = 1'b0;
    logic [1:0]      exc_target = 2'd0;
    logic            exc_return = 1'b0;
    logic [9:0]      ret_status = '0;
    logic [SP_W-1:0] sp_rdata;
    logic [9:0]      live_status;
    logic [9:0]      saved_status;
    logic [11:0]     vec_offset;

    banked_sp_select #(.SP_W(SP_W)) u_banked_sp_select (
        .clk(clk), .rst_n(rst_n),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
        .sel_wr_en(sel_wr_en), .sel_wr_data(sel_wr_data),
        .exc_enter(exc_enter), .exc_target(exc_target),
        .exc_return(exc_return), .ret_status(ret_status),
        .sp_rdata(sp_rdata), .live_status(live_status),
        .saved_status(saved_status), .vec_offset(vec_offset)
    );

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference model
    logic [1:0]      m_lvl = 2'd3;
    logic            m_sel = 1'b1;
    logic [3:0]      m_mask = 4'hF;
    logic [SP_W-1:0] m_bank [4];
    logic [9:0]      m_saved = '0;
    logic [11:0]     m_vec = '0;

    function automatic logic [1:0] map_idx(input logic [1:0] l, input logic s);
        return (l == 2'd0 || !s) ? 2'd0 : l;
    endfunction

    function automatic logic [9:0] m_live();
        return {m_mask, 2'b00, m_lvl, 1'b0, m_sel};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "sp_rdata", 32'(sp_rdata), 32'(m_bank[map_idx(m_lvl, m_sel)]));
        chk(tag, "live_status", 32'(live_status), 32'(m_live()));
        chk(tag, "saved_status", 32'(saved_status), 32'(m_saved));
        chk(tag, "vec_offset", 32'(vec_offset), 32'(m_vec));
    endtask

    // One cycle: drive at negedge, update model at posedge, check at next negedge
    task automatic step(input string tag,
                        input logic spw, input logic [SP_W-1:0] spd,
                        input logic sw, input logic sd,
                        input logic en, input logic [1:0] tg,
                        input logic rt, input logic [9:0] rs);
        logic ent_ok;
        logic ret_ok;
        sp_wr_en = spw; sp_wr_data = spd;
        sel_wr_en = sw; sel_wr_data = sd;
        exc_enter = en; exc_target = tg;
        exc_return = rt; ret_status = rs;
        @(posedge clk);
        ent_ok = en && (tg != 2'd0) && (tg >= m_lvl);
        ret_ok = rt && (rs[5:4] == 2'b00) && !rs[1];
        if (spw) m_bank[map_idx(m_lvl, m_sel)] = spd;          // R11 old mapping
        if (ent_ok) begin
            m_saved = m_live();
            if (tg != m_lvl) m_vec = 12'h400;
            else if (map_idx(m_lvl, m_sel) == 2'd0) m_vec = 12'h000;
            else m_vec = 12'h200;
            m_lvl = tg; m_sel = 1'b1; m_mask = 4'hF;
        end else if (ret_ok) begin
            m_lvl = rs[3:2]; m_sel = rs[0]; m_mask = rs[9:6];
        end else if (sw) begin
            m_sel = sd;
        end
        @(negedge clk);
        sp_wr_en = 1'b0; sel_wr_en = 1'b0; exc_enter = 1'b0; exc_return = 1'b0;
        check_all(tag);
    endtask

    task automatic goto_mode(input logic [1:0] l, input logic s, input logic [3:0] m);
        step("R9", 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, {m, 2'b00, l, 1'b0, s});
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_bank[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");
        chk("R1", "live_status reset code", 32'(live_status), 32'h3CD);

        // Fill each bank with a distinct value through its own mapping (R3, R2)
        for (int l = 1; l < 4; l++) begin
            goto_mode(2'(l), 1'b1, 4'h0);
            step("R3", 1'b1, SP_W'(16'h1000 + l), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, '0);
        end
        goto_mode(2'd2, 1'b0, 4'h5);
        step("R3", 1'b1, SP_W'(16'h0AAA), 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, '0);
        for (int l = 0; l < 4; l++) begin
            goto_mode(2'(l), 1'b1, 4'hA);
            chk("R2", "sp_rdata per level", 32'(sp_rdata),
                (l == 0) ? 32'h0AAA : 32'(16'h1000 + l));
        end

        // Sweep every mode, every target, with concurrent writes
        for (int l = 0; l < 4; l++) begin
            for (int s = 0; s < 2; s++) begin
                for (int t = 0; t < 4; t++) begin
                    goto_mode(2'(l), 1'(s), 4'(l * 4 + s + t));
                    step("R4", 1'b0, '0, 1'b1, ~1'(s), 1'b0, 2'd0, 1'b0, '0);
                    step("R4", 1'b0, '0, 1'b1, 1'(s), 1'b0, 2'd0, 1'b0, '0);
                    step("R7", 1'b1, SP_W'(16'h2000 + l * 64 + s * 16 + t),
                         1'b1, 1'b0, 1'b1, 2'(t), 1'b1, 10'h000);
                    step("R8", 1'b0, '0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, '0);
                    // handler flips the flag, then returns with the saved word
                    step("R9", 1'b0, '0, 1'b1, ~m_sel, 1'b0, 2'd0, 1'b0, '0);
                    step("R9", 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, m_saved);
                    // bank read back after toggling the flag
                    step("R3", 1'b0, '0, 1'b1, ~m_sel, 1'b0, 2'd0, 1'b0, '0);
                end
            end
        end

        // Return with reserved bits set is ignored (R10), flag write still applies (R11)
        goto_mode(2'd1, 1'b0, 4'h3);
        for (int b = 0; b < 3; b++) begin
            step("R10", 1'b0, '0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1,
                 10'h3CD | ((b == 0) ? 10'h002 : (b == 1) ? 10'h010 : 10'h020));
            chk("R10", "level kept", 32'(live_status[3:2]), 32'd1);
        end
        step("R11", 1'b0, '0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 10'h002);
        chk("R11", "flag write after bad return", 32'(live_status[0]), 32'd1);
        // Return beats flag write
        step("R11", 1'b0, '0, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 10'h0C8);
        chk("R11", "return over flag write", 32'(live_status), 32'h0C8);
        // Entry to lower level ignored, same level SPx class
        step("R8", 1'b0, '0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, '0);
        chk("R8", "lower target ignored", 32'(live_status), 32'h0C8);
        step("R7", 1'b0, '0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b0, '0);
        chk("R7", "same level shared stack vec", 32'(vec_offset), 32'h000);
        chk("R6", "saved word", 32'(saved_status), 32'h0C8);
        step("R7", 1'b0, '0, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, '0);
        chk("R7", "same level own stack vec", 32'(vec_offset), 32'h200);
        chk("R5", "entry live word", 32'(live_status), 32'h3C9);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule